// File: doc/BRIEF.md
# Command Completion Event Counter

This block is the per-channel status register through which a transfer engine reports finished commands to software. Each completed command arrives as a single-cycle pulse and advances a 6-bit hardware tally. Software keeps a second 6-bit tally, the processed count, in the same register. It acknowledges work by writing back the hardware tally it last read into the processed field. The number of events still waiting is the hardware tally minus the processed tally, modulo 64.

An interrupt-active flag is set by every event. Software clears it by writing the register with that flag bit low. The interrupt line is level-sensitive and active high. It stays asserted while the flag is set or while the two tallies differ. Because the hardware tally can move between a read and the write that follows it, an event that lands in the same cycle as a write is still counted. The next read shows it, and the interrupt stays up.

Top module: `cmdEvtCounter`

## Requirements
- R1: After reset the read data is all zero and the interrupt output is low.
- R2: Each cycle with the event pulse high increments the done count (read bits 5:0) by one, wrapping from 63 to 0. In cycles without a pulse the done count holds.
- R3: A register write loads write-data bits 21:16 into the processed count (read bits 21:16). Write-data bits 5:0 never change the done count.
- R4: A write with data bit 8 low clears the interrupt-active flag (read bit 8) when no event arrives in that cycle. A write with bit 8 high leaves the flag as it was.
- R5: An event sets the interrupt-active flag. An event arriving in the same cycle as a write is still counted and leaves the flag set, whatever bit 8 of the write data is.
- R6: The interrupt output is high exactly when the flag is set or the done count differs from the processed count.
- R7: Writing back the observed done count with bit 8 low, with no event in that cycle, drops the interrupt in the following cycle. Pending work is done minus processed, modulo 64.
- R8: Read bits outside 5:0, 8 and 21:16 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 1 | One-cycle pulse per completed command |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Current register contents |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions assume that the event pulse and the write strobe are clean, defined levels sampled at each rising edge. They also assume that reset is held for at least one edge before either input is used. The bench drives every input on the falling edge and keeps both strobes low during reset. It steps through all four combinations of event and write, including same-cycle collisions. It also sweeps every processed value and loops the done count past its wrap several times.

// File: rtl/cmdEvtPkg.sv
package cmdEvtPkg;
  typedef struct packed {
    logic incDone;
    logic loadProc;
    logic setFlag;
    logic clrFlag;
  } evtStrobes_t;
endpackage

// File: rtl/cmdEvtCtrl.sv
module cmdEvtCtrl
  import cmdEvtPkg::*;
(
  input  logic        evtPulse,
  input  logic        wrEn,
  input  logic        wrFlagBit,
  output evtStrobes_t strobes
);
  always_comb begin
    strobes.incDone  = evtPulse;
    strobes.loadProc = wrEn;
    strobes.setFlag  = evtPulse;
    // an event in the same cycle wins over a clearing write
    strobes.clrFlag  = wrEn && !wrFlagBit && !evtPulse;
  end
endmodule

// File: rtl/cmdEvtData.sv
module cmdEvtData
  import cmdEvtPkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int DATA_W   = 32,
  parameter int FLAG_POS = 8,
  parameter int PROC_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evtStrobes_t       strobes,
  input  logic [CNT_W-1:0]  procIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [CNT_W-1:0] doneCnt;
  logic [CNT_W-1:0] procCnt;
  logic             intFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneCnt <= '0;
      procCnt <= '0;
      intFlag <= 1'b0;
    end else begin
      if (strobes.incDone)  doneCnt <= doneCnt + 1'b1;
      if (strobes.loadProc) procCnt <= procIn;
      if (strobes.setFlag)      intFlag <= 1'b1;
      else if (strobes.clrFlag) intFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[CNT_W-1:0] = doneCnt;
    rdData[FLAG_POS] = intFlag;
    rdData[PROC_LSB +: CNT_W] = procCnt;
  end

  assign irq = intFlag || (doneCnt != procCnt);
endmodule

// File: rtl/cmdEvtCounter.sv
module cmdEvtCounter
  import cmdEvtPkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int DATA_W   = 32,
  parameter int FLAG_POS = 8,
  parameter int PROC_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtPulse,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  evtStrobes_t strobes;

  cmdEvtCtrl i_ctrl (
    .evtPulse (evtPulse),
    .wrEn     (wrEn),
    .wrFlagBit(wrData[FLAG_POS]),
    .strobes  (strobes)
  );

  cmdEvtData #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .FLAG_POS(FLAG_POS), .PROC_LSB(PROC_LSB)
  ) i_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .procIn (wrData[PROC_LSB +: CNT_W]),
    .rdData (rdData),
    .irq    (irq)
  );
endmodule

// File: rtl/cmdEvtCounterChk.sv
module cmdEvtCounterChk #(
  parameter int CNT_W    = 6,
  parameter int DATA_W   = 32,
  parameter int FLAG_POS = 8,
  parameter int PROC_LSB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evtPulse,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irq
);
  logic [CNT_W-1:0] doneV;
  logic [CNT_W-1:0] procV;
  assign doneV = rdData[CNT_W-1:0];
  assign procV = rdData[PROC_LSB +: CNT_W];

  // R2
  done_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evtPulse |=> doneV == CNT_W'($past(doneV) + 1'b1));
  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evtPulse |=> $stable(doneV));
  // R3
  proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> procV == $past(wrData[PROC_LSB +: CNT_W]));
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrData[FLAG_POS] && !evtPulse) |=> !rdData[FLAG_POS]);
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evtPulse |=> (rdData[FLAG_POS] && irq));
  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrData[FLAG_POS] && !evtPulse &&
     wrData[PROC_LSB +: CNT_W] == doneV) |=> !irq);
  // R6
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneV != procV) |-> irq);
endmodule

bind cmdEvtCounter cmdEvtCounterChk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .FLAG_POS(FLAG_POS), .PROC_LSB(PROC_LSB)
) i_chk (
  .clk(clk), .rst_n(rst_n), .evtPulse(evtPulse), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .irq(irq)
);

// File: tb/test_cmdEvtCounter.sv
module test_cmdEvtCounter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evtPulse = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;
  logic [5:0] mDone = '0;
  logic [5:0] mProc = '0;
  logic       mFlag = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdEvtCounter i_cmdEvtCounter (
    .clk(clk), .rst_n(rst_n), .evtPulse(evtPulse), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] expRd();
    logic [31:0] v = '0;
    v[5:0] = mDone;
    v[8] = mFlag;
    v[21:16] = mProc;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check({req, " rdData"}, rdData, expRd());
    check({req, " irq (R6)"}, {31'b0, irq}, {31'b0, mFlag || (mDone != mProc)});
  endtask

  // drive on falling edge, update model at rising edge, check after it
  task automatic step(input logic e, input logic w, input logic [31:0] d, input string req);
    @(negedge clk);
    evtPulse = e; wrEn = w; wrData = d;
    @(posedge clk);
    if (e) mDone = mDone + 1'b1;
    if (w) mProc = d[21:16];
    if (e) mFlag = 1'b1;
    else if (w && !d[8]) mFlag = 1'b0;
    #1;
    checkState(req);
    @(negedge clk);
    evtPulse = 1'b0; wrEn = 1'b0; wrData = '0;
  endtask

  function automatic logic [31:0] ackWord(input logic [5:0] p, input logic f, input logic [5:0] junk);
    logic [31:0] v = 32'hFFC0_FEC0;
    v[5:0] = junk;
    v[8] = f;
    v[21:16] = p;
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkState("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: run the done count through two wraps
    for (int i = 0; i < 130; i++) step(1'b1, 1'b0, '0, "R2 increment/wrap");
    check("R2 wrapped value", {26'b0, rdData[5:0]}, 32'd2);

    // R7: acknowledge observed done count, interrupt drops
    step(1'b0, 1'b1, ackWord(rdData[5:0], 1'b0, 6'h00), "R7 ack");
    check("R7 irq low after ack", {31'b0, irq}, 32'd0);

    // R3/R6: sweep every processed value, junk in bits 5:0 ignored
    for (int p = 0; p < 64; p++)
      step(1'b0, 1'b1, ackWord(6'(p), 1'b0, ~6'(p)), "R3 proc sweep / R6");

    // R4: bit 8 set keeps flag
    step(1'b1, 1'b0, '0, "R5 event sets flag");
    step(1'b0, 1'b1, ackWord(mDone, 1'b1, 6'h3F), "R4 bit8 high keeps flag");
    check("R4 flag kept", {31'b0, rdData[8]}, 32'd1);
    step(1'b0, 1'b1, ackWord(mDone, 1'b0, 6'h15), "R4 bit8 low clears flag");

    // R5: event collides with a clearing ack
    step(1'b1, 1'b1, ackWord(mDone, 1'b0, 6'h00), "R5 collision");
    check("R5 collision irq", {31'b0, irq}, 32'd1);
    check("R5 pending after collision", {26'b0, 6'(rdData[5:0] - rdData[21:16])}, 32'd1);

    // near-exhaustive mixed traffic, R8 via full-word compare
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[1],
           lfsr[2] ? ackWord(mDone, lfsr[3], lfsr[9:4]) : {lfsr[31:4], lfsr[3:0]},
           "R8 mixed traffic");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule